// File: doc/BRIEF.md
# Gain-Control Threshold Indicator Generator

This block sits behind a converter that delivers one signed sample per clock. It turns each sample into an unsigned magnitude. From that magnitude it drives two flags that an external gain controller reads.

The decrement flag is a fast overrange warning. By default it compares only the top few bits of the magnitude against a small coarse threshold. A control bit can switch it to a full-resolution upper threshold instead. That path has the same meaning but two extra cycles of latency. The increment flag asks for more gain. It rises only after the magnitude has stayed strictly below a full-resolution lower threshold for a programmable number of consecutive samples. Any sample at or above that threshold restarts the count. Both flags follow each sample, not an envelope. Each flag, once raised, stays up for at least two cycles.

Thresholds, the dwell count and the enables are loaded through a single-cycle write port. The register map is:

| Address | Contents | Reset value |
|---|---|---|
| 0 | control: bit0 = decrement enable, bit1 = increment enable, bit2 = upper source select (1 = fine) | 0 |
| 1 | coarse upper threshold, bits [2:0] | 7 |
| 2 | fine upper threshold, bits [12:0] | 8191 |
| 3 | fine lower threshold, bits [12:0] | 0 |
| 4 | dwell count, bits [15:0] | 1 |

Top module: `gain_flag_gen`

## Requirements
- R1: While reset is held and after it is released, `dec_gain` and `inc_gain` are low, and they stay low while both enables are cleared.
- R2: The magnitude of a 14-bit two's-complement sample is its absolute value saturated to 13 bits, so -8192 maps to 8191.
- R3: With control bit0 = 1 and bit2 = 0, `dec_gain` is high after the second rising edge following a sample whose magnitude bits [12:10] exceed the coarse threshold. It stays high for as many consecutive samples as keep exceeding it.
- R4: With control bit2 = 1, the decrement decision compares the full 13-bit magnitude against the fine upper threshold (strictly greater). The result appears at `dec_gain` after the fourth rising edge following the sample.
- R5: With control bit1 = 1, `inc_gain` goes high after the fourth rising edge following the sample that completes a run of N consecutive samples whose magnitude is strictly below the fine lower threshold, where N is the dwell count. It stays high while the run continues.
- R6: A sample whose magnitude is greater than or equal to the fine lower threshold restarts the dwell count, so a new full run of N samples is needed.
- R7: A dwell count of 0 behaves as a dwell count of 1.
- R8: A write to the dwell register clears the dwell count on that edge, so the count of a run in progress starts over.
- R9: Once raised, either flag stays high for at least two cycles, even when its condition holds for one sample only.
- R10: A flag whose enable bit is 0 stays low, whatever the samples and thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 14 | Signed converter sample, one per clock |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| dec_gain | output | 1 | Decrement-gain request flag |
| inc_gain | output | 1 | Increment-gain request flag |

## Verification
A sample captured on edge k is due at `dec_gain` after edge k+2 on the coarse path and after edge k+4 on the fine path. The increment flag is due after edge k+4, where k is the last sample of a full below-threshold run. A write to the dwell register restarts the count on its own edge, so the flag is due exactly N edges after the write. The bench drives every input on the falling edge and then samples the outputs on the following falling edge. Each check is therefore indexed by how many rising edges have passed since the stimulus sample. Each scenario walks that index past both the expected rise and the expected fall, so an extra or a missing pipeline stage shows up as a mismatch.

// File: rtl/gain_flag_gen.sv
module gain_flag_gen #(
  parameter int SMP_W   = 14,
  parameter int CRS_W   = 3,
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SMP_W-1:0]   smp_in,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [DWELL_W-1:0] cfg_wdata,
  output logic               dec_gain,
  output logic               inc_gain
);
  localparam int MAG_W = SMP_W - 1;
  localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};

  logic [2:0]         ctrl_q;
  logic [CRS_W-1:0]   crs_thr_q;
  logic [MAG_W-1:0]   fup_thr_q, flo_thr_q;
  logic [DWELL_W-1:0] dwell_q;

  wire dwell_wr = cfg_we && (cfg_addr == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      crs_thr_q <= '1;
      fup_thr_q <= '1;
      flo_thr_q <= '0;
      dwell_q   <= DWELL_W'(1);
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: ctrl_q    <= cfg_wdata[2:0];
        3'd1: crs_thr_q <= cfg_wdata[CRS_W-1:0];
        3'd2: fup_thr_q <= cfg_wdata[MAG_W-1:0];
        3'd3: flo_thr_q <= cfg_wdata[MAG_W-1:0];
        3'd4: dwell_q   <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // magnitude: absolute value, saturated to MAG_W bits
  wire [SMP_W-1:0] abs_v   = smp_in[SMP_W-1] ? (~smp_in + SMP_W'(1)) : smp_in;
  wire [MAG_W-1:0] mag_now = abs_v[SMP_W-1] ? {MAG_W{1'b1}} : abs_v[MAG_W-1:0];

  logic [MAG_W-1:0] mag_r, mag_d1, mag_d2;
  logic [2:0]       vld;
  logic             crs_hit_q, fup_hit_q, below_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag_r     <= '0;
      mag_d1    <= '0;
      mag_d2    <= '0;
      vld       <= '0;
      crs_hit_q <= 1'b0;
      fup_hit_q <= 1'b0;
      below_q   <= 1'b0;
    end else begin
      mag_r     <= mag_now;
      vld       <= {vld[1:0], 1'b1};
      crs_hit_q <= mag_r[MAG_W-1 -: CRS_W] > crs_thr_q;
      mag_d1    <= mag_r;
      mag_d2    <= mag_d1;
      fup_hit_q <= mag_d2 > fup_thr_q;
      below_q   <= vld[2] && (mag_d2 < flo_thr_q);
    end
  end

  // dwell timer
  logic [DWELL_W-1:0] dwell_cnt;
  wire  [DWELL_W-1:0] cnt_inc   = (dwell_cnt == '1) ? dwell_cnt : dwell_cnt + DWELL_W'(1);
  wire  [DWELL_W-1:0] dwell_eff = (dwell_q == '0) ? DWELL_W'(1) : dwell_q;

  always_ff @(posedge clk) begin
    if (!rst_n || dwell_wr || !below_q) dwell_cnt <= '0;
    else                                dwell_cnt <= cnt_inc;
  end

  wire dec_cond = ctrl_q[2] ? fup_hit_q : crs_hit_q;
  wire inc_cond = below_q && !dwell_wr && (cnt_inc >= dwell_eff);

  // flags with a two-cycle minimum width
  logic dec_q2, inc_q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_gain <= 1'b0;
      inc_gain <= 1'b0;
      dec_q2   <= 1'b0;
      inc_q2   <= 1'b0;
    end else begin
      dec_gain <= ctrl_q[0] && (dec_cond || (dec_gain && !dec_q2));
      inc_gain <= ctrl_q[1] && (inc_cond || (inc_gain && !inc_q2));
      dec_q2   <= dec_gain;
      inc_q2   <= inc_gain;
    end
  end

  assert_sat_full_scale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_in == MOST_NEG) |=> (mag_r == {MAG_W{1'b1}}));

  assert_coarse_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !ctrl_q[2] && crs_hit_q) |=> dec_gain);

  assert_inc_needs_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inc_gain) |-> $past(below_q));

  assert_dec_min_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_gain) |=> (dec_gain || !ctrl_q[0]));

  assert_inc_min_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inc_gain) |=> (inc_gain || !ctrl_q[1]));

  assert_inc_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl_q[1]) |-> !inc_gain);
endmodule

// File: tb/gain_flag_gen_test.sv
module gain_flag_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] smp = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        dec_gain, inc_gain;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  gain_flag_gen uut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dec_gain(dec_gain), .inc_gain(inc_gain)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int s);
    smp = 14'(s);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill(input int s, input int n);
    for (int i = 0; i < n; i++) step(s);
  endtask

  task automatic t_reset;
    chk(dec_gain, 1'b0, "R1 dec after reset");
    chk(inc_gain, 1'b0, "R1 inc after reset");
    for (int i = 0; i < 6; i++) begin
      step(0);
      chk(dec_gain | inc_gain, 1'b0, "R1 idle flags");
    end
  endtask

  task automatic t_coarse;
    wr(1, 3); wr(0, 1); fill(0, 6);
    step(5000);
    for (int i = 1; i <= 5; i++) begin
      step(0);
      chk(dec_gain, (i == 2 || i == 3), $sformatf("R3/R9 single pulse edge %0d", i));
    end
    step(-5000);
    for (int i = 1; i <= 5; i++) begin
      step(0);
      chk(dec_gain, (i == 2 || i == 3), $sformatf("R2 negative sample edge %0d", i));
    end
    for (int i = 0; i <= 8; i++) begin
      step(i < 5 ? 6000 : 0);
      chk(dec_gain, (i >= 2 && i <= 6), $sformatf("R3 long run edge %0d", i));
    end
    for (int i = 0; i <= 5; i++) begin
      step(i == 0 ? 4095 : 0);
      chk(dec_gain, 1'b0, $sformatf("R3 top bits equal edge %0d", i));
    end
  endtask

  task automatic t_fine;
    wr(2, 8190); wr(0, 5); fill(0, 6);
    for (int i = 0; i <= 6; i++) begin
      step(i == 0 ? -8192 : 0);
      chk(dec_gain, (i == 4 || i == 5), $sformatf("R2/R4 full-scale negative edge %0d", i));
    end
    for (int i = 0; i <= 6; i++) begin
      step(i == 0 ? 8190 : 0);
      chk(dec_gain, 1'b0, $sformatf("R4 equal to fine upper edge %0d", i));
    end
    wr(2, 5000); fill(0, 6);
    for (int i = 0; i <= 6; i++) begin
      step(i == 0 ? 5001 : 0);
      chk(dec_gain, (i == 4 || i == 5), $sformatf("R4 fine resolution edge %0d", i));
    end
  endtask

  task automatic t_dwell;
    wr(0, 2); wr(3, 100); wr(4, 4); fill(500, 6);
    for (int i = 0; i <= 10; i++) begin
      step(10);
      chk(inc_gain, (i >= 7), $sformatf("R5 dwell 4 edge %0d", i));
    end
    for (int j = 0; j <= 5; j++) begin
      step(500);
      chk(inc_gain, (j < 4), $sformatf("R5 release edge %0d", j));
    end
  endtask

  task automatic t_restart;
    wr(0, 2); wr(3, 100); wr(4, 4); fill(500, 6);
    for (int i = 0; i <= 12; i++) begin
      step(i == 3 ? 100 : -10);
      chk(inc_gain, (i >= 11), $sformatf("R6 restart at threshold edge %0d", i));
    end
  endtask

  task automatic t_dwell0;
    wr(0, 2); wr(3, 100); wr(4, 0); fill(500, 6);
    for (int i = 0; i <= 7; i++) begin
      step(i == 0 ? 10 : 500);
      chk(inc_gain, (i == 4 || i == 5), $sformatf("R7/R9 dwell zero pulse edge %0d", i));
    end
  endtask

  task automatic t_rewrite;
    wr(0, 2); wr(3, 100); wr(4, 8); fill(500, 6);
    fill(10, 5);
    wr(4, 8);
    chk(inc_gain, 1'b0, "R8 at rewrite");
    for (int j = 1; j <= 9; j++) begin
      step(10);
      chk(inc_gain, (j >= 8), $sformatf("R8 after rewrite edge %0d", j));
    end
  endtask

  task automatic t_enable;
    wr(0, 0); wr(1, 0); wr(3, 8191); wr(4, 1);
    for (int i = 0; i < 8; i++) begin
      step(i < 4 ? 7000 : 10);
      chk(dec_gain, 1'b0, "R10 dec disabled");
      chk(inc_gain, 1'b0, "R10 inc disabled");
    end
  endtask

  initial begin
    fill(0, 4);
    rst_n = 1'b1;
    t_reset;
    t_coarse;
    t_fine;
    t_dwell;
    t_restart;
    t_dwell0;
    t_rewrite;
    t_enable;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule